// File: doc/BRIEF.md
# Timer Channel Event-Flag Register

This block holds the sticky event flags of one 16-bit timer channel and turns them into interrupt requests. Three strobes arrive from the channel datapath: the counter wrapping past its top or bottom value, a match or capture on general register A, and a match or capture on general register B. Each strobe sets its own flag, and the flag stays set until software clears it. The counter, the compare and capture logic and the interrupt controller are outside the block.

Software sees the flags through an 8-bit register with a one-cycle read strobe and a one-cycle write strobe. Clearing uses a two-step handshake. The CPU must first read a flag while it is 1. A later write of 0 to that bit then clears it. Writes of 1 do nothing, and a write of 0 without a prior qualifying read does nothing. Reset and a standby input both return the register to its initial image. Each flag drives a registered interrupt request, gated by an enable bit.

Top module: `tsf_status_top`

## Requirements
- R1: After reset, `rd_data` reads 0xF8 and `irq_req` is 0.
- R2: The status image carries the overflow flag on bit 2, the register-B flag on bit 1 and the register-A flag on bit 0. Bits 7 to 3 always read 1.
- R3: A strobe on `ovf_evt`, `cmp_a_evt` or `cmp_b_evt` sets its flag in the cycle after the strobe. The flag then stays set with no further strobe.
- R4: `unf_evt` sets the overflow flag only while `updown_mode` is 1. While `updown_mode` is 0, the underflow strobe leaves the flags unchanged.
- R5: A write whose data bit is 0 clears that flag one cycle later, but only if a read of the register happened while the flag was 1 and before any other write.
- R6: A write whose data bit is 1 leaves the flag unchanged. A write of 0 with no qualifying read since the last write also leaves the flag unchanged.
- R7: Every write drops the read qualification of all three flags. A read arms only the flags that are 1 in that cycle. A read in the same cycle as a write arms nothing.
- R8: When a set strobe coincides with a clearing write to the same flag, the flag stays 1.
- R9: `irq_req[i]` is the flag on the same bit position ANDed with `irq_en[i]`, through one register. It therefore rises one cycle after the flag and falls one cycle after the flag clears.
- R10: `standby` high has the same effect as reset. Flags go to 0, `rd_data` reads 0xF8, read qualifications are dropped, and `irq_req` goes to 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Synchronous reinitialisation request |
| updown_mode | input | 1 | Channel counts both ways; enables underflow |
| ovf_evt | input | 1 | Counter wrapped upward |
| unf_evt | input | 1 | Counter wrapped downward |
| cmp_a_evt | input | 1 | Match or capture on general register A |
| cmp_b_evt | input | 1 | Match or capture on general register B |
| rd_en | input | 1 | CPU read strobe for the status register |
| wr_en | input | 1 | CPU write strobe for the status register |
| wr_data | input | 8 | CPU write data |
| irq_en | input | 3 | Interrupt enables, same bit order as the flags |
| rd_data | output | 8 | Status register image |
| irq_req | output | 3 | Registered interrupt requests, same bit order as the flags |

## Verification
The assertions assume that the read and write strobes last one cycle each. They also assume that the event strobes are already qualified single-cycle pulses from the channel, so a strobe held high counts as a repeated event. The stimulus drives every input on the falling clock edge and raises each strobe for exactly one cycle. It uses a standby pulse to begin each scenario from the initial image, so the armed state left by one sweep point cannot leak into the next. The sweep covers all flag patterns against all write values. It then coincides events with writes and reads with writes, and toggles `updown_mode` around the underflow strobe.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    localparam int REG_W  = 8;
    localparam int NFLAG  = 3;
    localparam int RSVD_W = REG_W - NFLAG;

    // Bit positions inside the status image (software decodes these)
    localparam int BIT_GA  = 0;
    localparam int BIT_GB  = 1;
    localparam int BIT_OVF = 2;

    // Packed in MSB-first order so the struct maps onto bits 2..0
    typedef struct packed {
        logic ovf;
        logic gb;
        logic ga;
    } flag_vec_t;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [REG_W-1:0] wdata;
    } cpu_req_t;

    localparam logic [REG_W-1:0] RSVD_ONES = {{RSVD_W{1'b1}}, {NFLAG{1'b0}}};

    function automatic logic [REG_W-1:0] status_image(flag_vec_t f);
        return RSVD_ONES | {{RSVD_W{1'b0}}, f};
    endfunction

    function automatic logic [NFLAG-1:0] flag_bits(flag_vec_t f);
        return f;
    endfunction

endpackage

// File: rtl/tsf_event_qual.sv
module tsf_event_qual
    import tsf_pkg::*;
(
    input  logic      updown_mode,
    input  logic      ovf_evt,
    input  logic      unf_evt,
    input  logic      cmp_a_evt,
    input  logic      cmp_b_evt,
    output flag_vec_t set_v
);
    logic unf_ok;

    // Downward wrap is only meaningful when the channel counts both ways
    assign unf_ok = unf_evt & updown_mode;

    always_comb begin
        set_v     = '0;
        set_v.ovf = ovf_evt | unf_ok;
        set_v.gb  = cmp_b_evt;
        set_v.ga  = cmp_a_evt;
    end
endmodule

// File: rtl/tsf_flag_cell.sv
module tsf_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic standby,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o,
    output logic armed_o
);
    logic flag_q;
    logic armed_q;
    logic clr_ok;

    assign clr_ok = wr_i & armed_q & ~wbit_i;

    always_ff @(posedge clk) begin
        if (rst || standby) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (set_i)
                flag_q <= 1'b1;
            else if (clr_ok)
                flag_q <= 1'b0;

            if (wr_i)
                armed_q <= 1'b0;
            else if (rd_i && flag_q)
                armed_q <= 1'b1;
        end
    end

    assign flag_o  = flag_q;
    assign armed_o = armed_q;

    p_set_sticky_r3: assert property (@(posedge clk) disable iff (rst || standby)
        set_i |=> flag_o);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst || standby)
        (set_i && wr_i && !wbit_i) |=> flag_o);

    p_clear_armed_r5: assert property (@(posedge clk) disable iff (rst || standby)
        (wr_i && armed_o && !wbit_i && !set_i) |=> !flag_o);

    p_keep_unarmed_r6: assert property (@(posedge clk) disable iff (rst || standby)
        (wr_i && !set_i && (!armed_o || wbit_i)) |=> (flag_o == $past(flag_o)));

    p_write_disarms_r7: assert property (@(posedge clk) disable iff (rst || standby)
        wr_i |=> !armed_o);

    p_arm_needs_flag_r7: assert property (@(posedge clk) disable iff (rst || standby)
        (!wr_i && !flag_o) |=> (armed_o == $past(armed_o)));
endmodule

// File: rtl/tsf_irq_gen.sv
module tsf_irq_gen
    import tsf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             standby,
    input  flag_vec_t        flags,
    input  logic [NFLAG-1:0] en,
    output logic [NFLAG-1:0] irq
);
    logic [NFLAG-1:0] irq_q;

    for (genvar i = 0; i < NFLAG; i++) begin : g_req
        always_ff @(posedge clk) begin
            if (rst || standby)
                irq_q[i] <= 1'b0;
            else
                irq_q[i] <= flags[i] & en[i];
        end
    end

    assign irq = irq_q;

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst || standby)
        ((flag_bits(flags) & en) == '0) |=> (irq == '0));

    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (rst || standby)
        (irq != '0) |-> ($past(flag_bits(flags) & en) != '0));
endmodule

// File: rtl/tsf_status_top.sv
module tsf_status_top
    import tsf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             standby,
    input  logic             updown_mode,
    input  logic             ovf_evt,
    input  logic             unf_evt,
    input  logic             cmp_a_evt,
    input  logic             cmp_b_evt,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [NFLAG-1:0] irq_en,
    output logic [REG_W-1:0] rd_data,
    output logic [NFLAG-1:0] irq_req
);
    cpu_req_t         req;
    flag_vec_t        set_v;
    flag_vec_t        flags;
    logic [NFLAG-1:0] set_bits;
    logic [NFLAG-1:0] flag_bits_w;
    logic [NFLAG-1:0] armed;

    assign req.rd    = rd_en;
    assign req.wr    = wr_en;
    assign req.wdata = wr_data;

    tsf_event_qual u_qual (
        .updown_mode (updown_mode),
        .ovf_evt     (ovf_evt),
        .unf_evt     (unf_evt),
        .cmp_a_evt   (cmp_a_evt),
        .cmp_b_evt   (cmp_b_evt),
        .set_v       (set_v)
    );

    assign set_bits = set_v;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        tsf_flag_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .standby (standby),
            .set_i   (set_bits[i]),
            .rd_i    (req.rd),
            .wr_i    (req.wr),
            .wbit_i  (req.wdata[i]),
            .flag_o  (flag_bits_w[i]),
            .armed_o (armed[i])
        );
    end

    assign flags   = flag_vec_t'(flag_bits_w);
    assign rd_data = status_image(flags);

    tsf_irq_gen u_irq (
        .clk     (clk),
        .rst     (rst),
        .standby (standby),
        .flags   (flags),
        .en      (irq_en),
        .irq     (irq_req)
    );

    p_unf_masked_r4: assert property (@(posedge clk) disable iff (rst || standby)
        (unf_evt && !updown_mode && !ovf_evt && !flags.ovf) |=> !flags.ovf);

    p_unf_sets_r4: assert property (@(posedge clk) disable iff (rst || standby)
        (unf_evt && updown_mode) |=> flags.ovf);

    p_standby_init_r10: assert property (@(posedge clk) disable iff (rst)
        standby |=> (rd_data == RSVD_ONES && armed == '0 && flag_bits_w == '0));

    p_standby_irq_r10: assert property (@(posedge clk) disable iff (rst)
        (standby && $past(standby)) |-> (irq_req == '0));
endmodule

// File: tb/tb_tsf_status_top.sv
`timescale 1ns/1ps
module tb_tsf_status_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       standby = 1'b0;
    logic       updown_mode = 1'b0;
    logic       ovf_evt = 1'b0;
    logic       unf_evt = 1'b0;
    logic       cmp_a_evt = 1'b0;
    logic       cmp_b_evt = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] irq_en = 3'b000;
    logic [7:0] rd_data;
    logic [2:0] irq_req;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tsf_status_top dut (
        .clk(clk), .rst(rst), .standby(standby), .updown_mode(updown_mode),
        .ovf_evt(ovf_evt), .unf_evt(unf_evt), .cmp_a_evt(cmp_a_evt),
        .cmp_b_evt(cmp_b_evt), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .irq_en(irq_en), .rd_data(rd_data), .irq_req(irq_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_stat(input string req, input logic [2:0] f);
        check(rd_data == (8'hF8 | {5'b0, f}), req, rd_data, 8'hF8 | {5'b0, f});
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic events(input logic [2:0] p);
        cmp_a_evt = p[0]; cmp_b_evt = p[1]; ovf_evt = p[2];
        step();
        cmp_a_evt = 0; cmp_b_evt = 0; ovf_evt = 0;
    endtask

    task automatic do_read();
        rd_en = 1; step(); rd_en = 0;
    endtask

    task automatic do_write(input logic [7:0] v);
        wr_en = 1; wr_data = v; step(); wr_en = 0; wr_data = 8'h00;
    endtask

    task automatic sb_pulse();
        standby = 1; step(); step(); standby = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst = 0;
        // R1 R2: reset image
        chk_stat("R1", 3'b000);
        check(irq_req == 3'b000, "R1", irq_req, 0);

        // R5 R6 R2 R3: sweep flag pattern against write value, after a read
        for (int p = 0; p < 8; p++) begin
            for (int w = 0; w < 8; w++) begin
                sb_pulse();
                events(3'(p));
                chk_stat("R3", 3'(p));
                step();
                chk_stat("R3", 3'(p));
                do_read();
                do_write({5'(p * 3 + w), 3'(w)});
                chk_stat("R5", 3'(p & w));
            end
        end

        // R6: write 0 without a prior read
        sb_pulse();
        events(3'b111);
        do_write(8'h00);
        chk_stat("R6", 3'b111);
        // R6: write 1 after read, then R7: armed consumed by that write
        do_read();
        do_write(8'hFF);
        chk_stat("R6", 3'b111);
        do_write(8'h00);
        chk_stat("R7", 3'b111);

        // R7: read while the flag is 0 arms nothing
        sb_pulse();
        do_read();
        events(3'b001);
        do_write(8'h00);
        chk_stat("R7", 3'b001);

        // R7: read together with write arms nothing
        sb_pulse();
        events(3'b111);
        rd_en = 1; wr_en = 1; wr_data = 8'h00; step();
        rd_en = 0; wr_en = 0;
        chk_stat("R7", 3'b111);
        do_write(8'h00);
        chk_stat("R7", 3'b111);

        // R8: set strobe coincides with clearing write
        sb_pulse();
        events(3'b111);
        do_read();
        wr_en = 1; wr_data = 8'h00; cmp_a_evt = 1; step();
        wr_en = 0; cmp_a_evt = 0;
        chk_stat("R8", 3'b001);
        sb_pulse();
        events(3'b111);
        do_read();
        wr_en = 1; wr_data = 8'h00; ovf_evt = 1; step();
        wr_en = 0; ovf_evt = 0;
        chk_stat("R8", 3'b100);

        // R4: underflow masked outside up/down mode, honoured inside
        sb_pulse();
        updown_mode = 0;
        unf_evt = 1; step(); unf_evt = 0;
        chk_stat("R4", 3'b000);
        updown_mode = 1;
        unf_evt = 1; step(); unf_evt = 0;
        chk_stat("R4", 3'b100);
        updown_mode = 0;

        // R9: interrupt sweep over all enable values
        for (int e = 0; e < 8; e++) begin
            sb_pulse();
            irq_en = 3'(e);
            events(3'b111);
            check(irq_req == 3'b000, "R9", irq_req, 0);
            step();
            check(irq_req == 3'(e), "R9", irq_req, e);
            do_read();
            do_write(8'h00);
            chk_stat("R9", 3'b000);
            check(irq_req == 3'(e), "R9", irq_req, e);
            step();
            check(irq_req == 3'b000, "R9", irq_req, 0);
        end

        // R10: standby drops flags, irq and armed state
        irq_en = 3'b111;
        events(3'b111);
        step();
        do_read();
        check(irq_req == 3'b111, "R10", irq_req, 7);
        sb_pulse();
        chk_stat("R10", 3'b000);
        check(irq_req == 3'b000, "R10", irq_req, 0);
        events(3'b111);
        do_write(8'h00);
        chk_stat("R10", 3'b111);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule